// File: doc/BRIEF.md
# Status-Driven Burst Credit Limiter

This block guards the transmit side of a channelised packet interface. The far end reports a 2-bit fill status for each of its receive queues. On every status update the limiter grants that channel a budget counted in 16-byte blocks. The budget is one of two programmable limits: a larger one when the queue reports it is nearly empty ("starving") and a smaller one when it reports "hungry". A "satisfied" report removes any budget that is left. Each block the transmitter sends lowers that channel's budget by one. A per-channel `may_send` flag tells the scheduler which channels may still be served.

Both limits sit in one 32-bit configuration register inside the block. The register is written through a single write strobe. There are sixteen independent channels by default. The status and sent strobes each carry a channel index, so one channel changes per strobe. Calendar sequencing, status framing and parity checking belong to neighbouring logic.

Top module: `burst_credit_limiter`

## Requirements
- R1: After reset every `may_send` bit is 0. The configuration holds a starving limit of 6 blocks and a hungry limit of 2 blocks.
- R2: A status update with code 2'b00 (starving) sets the indexed channel's budget to the starving limit, which is taken from configuration bits 24:16.
- R3: A status update with code 2'b01 (hungry) sets the indexed channel's budget to the hungry limit, which is taken from configuration bits 8:0.
- R4: A status update with code 2'b10 (satisfied) sets the indexed channel's budget to zero.
- R5: A status update with code 2'b11 has no effect on any budget.
- R6: A status update replaces the remaining budget. It does not add to it.
- R7: Each sent strobe lowers the indexed channel's budget by one. A sent strobe on a channel whose budget is already zero leaves it at zero.
- R8: `may_send[i]` is 1 exactly when channel i's budget is non-zero. It reflects a strobe from the first cycle after the clock edge that samples the strobe.
- R9: A strobe changes only the channel named by its index. All other budgets keep their values.
- R10: When a status update (code other than 2'b11) and a sent strobe name the same channel in the same cycle, the status update decides the new budget and the sent strobe is dropped.
- R11: A configuration write replaces both limits. Bits outside 24:16 and 8:0 are ignored. The new limits apply to status updates from the cycle after the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data (starving limit in 24:16, hungry limit in 8:0) |
| stat_valid | input | 1 | Status update strobe |
| stat_chan | input | 4 | Channel index of the status update |
| stat_code | input | 2 | Status code: 00 starving, 01 hungry, 10 satisfied, 11 no action |
| sent_valid | input | 1 | One 16-byte block was sent |
| sent_chan | input | 4 | Channel index of the sent block |
| may_send | output | 16 | Per-channel permission flag, bit i for channel i |

## Verification
Every result of this block is due one clock edge after its strobe. A status load, a decrement or a configuration write is captured by a budget or limit register, and `may_send` is a plain OR of the budget bits. The bench drives each strobe at a falling edge and samples the full `may_send` vector at the next falling edge. At that point exactly one rising edge has passed, and the bench clears the strobe. Budget values are measured through the ports: the bench counts how many sent strobes keep the flag high, and compares that count with its own arithmetic model of all sixteen budgets.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

   typedef enum logic [1:0] {
      ST_STARVING  = 2'b00,
      ST_HUNGRY    = 2'b01,
      ST_SATISFIED = 2'b10,
      ST_NOACTION  = 2'b11
   } fifo_stat_e;

   // Budget granted for a status code; callers skip ST_NOACTION.
   function automatic logic [8:0] grant_for(input logic [1:0] code,
                                            input logic [8:0] lim_starve,
                                            input logic [8:0] lim_hungry);
      logic [8:0] g;
      case (code)
         ST_STARVING: g = lim_starve;
         ST_HUNGRY:   g = lim_hungry;
         default:     g = '0;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/bcl_cfg_reg.sv
module bcl_cfg_reg #(
   parameter int CFG_W     = 32,
   parameter int LIM_W     = 9,
   parameter int HI_LSB    = 16,
   parameter int RST_HI    = 6,
   parameter int RST_LO    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   output logic [LIM_W-1:0] lim_starve,
   output logic [LIM_W-1:0] lim_hungry
);

   localparam int HI_MSB = HI_LSB + LIM_W - 1;

   if (HI_MSB >= CFG_W) begin : g_bad_hi
      $error("bcl_cfg_reg: starving field exceeds register width");
   end
   if (LIM_W > HI_LSB) begin : g_bad_lo
      $error("bcl_cfg_reg: hungry field overlaps starving field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_starve <= LIM_W'(RST_HI);
         lim_hungry <= LIM_W'(RST_LO);
      end else if (wr) begin
         lim_starve <= wdata[HI_MSB:HI_LSB];
         lim_hungry <= wdata[LIM_W-1:0];
      end
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(lim_starve) && $stable(lim_hungry))); // R11

endmodule

// File: rtl/bcl_credit_counter.sv
module bcl_credit_counter #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             nonzero
);

   logic [CNT_W-1:0] cnt;

   if (CNT_W < 1) begin : g_bad_w
      $error("bcl_credit_counter: counter width must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (dec && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign nonzero = |cnt;

   AST_LOAD_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val)); // R6
   AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && dec && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R7
   AST_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt == '0) |=> cnt == '0); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !dec) |=> $stable(cnt)); // R9

endmodule

// File: rtl/burst_credit_limiter.sv
module burst_credit_limiter #(
   parameter int NUM_CH   = 16,
   parameter int CFG_W    = 32,
   parameter int LIM_W    = 9,
   parameter int RST_HI   = 6,
   parameter int RST_LO   = 2,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              stat_valid,
   input  logic [CH_W-1:0]   stat_chan,
   input  logic [1:0]        stat_code,
   input  logic              sent_valid,
   input  logic [CH_W-1:0]   sent_chan,
   output logic [NUM_CH-1:0] may_send
);
   import bcl_pkg::*;

   if (LIM_W != 9) begin : g_bad_lim
      $error("burst_credit_limiter: limit fields are 9 bits wide");
   end
   if (NUM_CH < 1 || NUM_CH > 256) begin : g_bad_ch
      $error("burst_credit_limiter: NUM_CH out of range");
   end

   logic [LIM_W-1:0] lim_starve, lim_hungry, grant;
   logic             stat_act;

   bcl_cfg_reg #(
      .CFG_W (CFG_W), .LIM_W (LIM_W), .HI_LSB (16),
      .RST_HI(RST_HI), .RST_LO(RST_LO)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .lim_starve(lim_starve), .lim_hungry(lim_hungry)
   );

   assign stat_act = stat_valid && (stat_code != ST_NOACTION);
   assign grant    = grant_for(stat_code, lim_starve, lim_hungry);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic ld, dc;
      assign ld = stat_act   && (stat_chan == CH_W'(i));
      assign dc = sent_valid && (sent_chan == CH_W'(i));
      bcl_credit_counter #(.CNT_W(LIM_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .load(ld), .load_val(grant),
         .dec(dc), .nonzero(may_send[i])
      );
   end

   AST_SATISFIED_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_code == ST_SATISFIED) |=> !may_send[$past(stat_chan)]); // R4
   AST_NOACTION_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_code == ST_NOACTION && !sent_valid) |=> $stable(may_send)); // R5
   AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_valid && !sent_valid) |=> $stable(may_send)); // R9

endmodule

// File: tb/sim_burst_credit_limiter.sv
module sim_burst_credit_limiter;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic [31:0] cfg_wdata;
   logic        stat_valid;
   logic [3:0]  stat_chan;
   logic [1:0]  stat_code;
   logic        sent_valid;
   logic [3:0]  sent_chan;
   logic [15:0] may_send;

   int checks = 0;
   int failures = 0;
   int budget [16];
   int m_starve, m_hungry;
   bit finished = 0;

   always #4 clk = ~clk;   // 125 MHz

   burst_credit_limiter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .stat_valid(stat_valid), .stat_chan(stat_chan), .stat_code(stat_code),
      .sent_valid(sent_valid), .sent_chan(sent_chan), .may_send(may_send)
   );

   function automatic logic [15:0] expect_vec();
      logic [15:0] v;
      for (int i = 0; i < 16; i++) v[i] = (budget[i] != 0);
      return v;
   endfunction

   task automatic check(input string req);
      logic [15:0] e;
      e = expect_vec();
      checks++;
      if (may_send !== e) begin
         failures++;
         $display("FAIL %s may_send actual=%h expected=%h", req, may_send, e);
      end
   endtask

   function automatic void apply_status(input int ch, input logic [1:0] code);
      case (code)
         2'b00: budget[ch] = m_starve;
         2'b01: budget[ch] = m_hungry;
         2'b10: budget[ch] = 0;
         default: ;
      endcase
   endfunction

   // Drive at a falling edge; result is sampled at the next falling edge.
   task automatic step(input string req, input bit sv, input int sc, input logic [1:0] code,
                       input bit dv, input int dch);
      stat_valid = sv; stat_chan = 4'(sc); stat_code = code;
      sent_valid = dv; sent_chan = 4'(dch);
      @(negedge clk);
      if (sv && code != 2'b11) apply_status(sc, code);
      if (dv && !(sv && code != 2'b11 && sc == dch) && budget[dch] > 0) budget[dch]--;
      stat_valid = 0; sent_valid = 0;
      check(req);
   endtask

   task automatic write_cfg(input logic [31:0] d);
      cfg_wr = 1; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 0;
      m_starve = int'(d[24:16]);
      m_hungry = int'(d[8:0]);
      check("R11");
   endtask

   // Load a channel, then send until the flag drops, plus one extra strobe.
   task automatic drain(input string req, input int ch, input logic [1:0] code);
      int n;
      step(req, 1, ch, code, 0, 0);
      n = budget[ch];
      for (int k = 0; k <= n; k++) step("R7", 0, 0, 2'b00, 1, ch);
   endtask

   initial begin
      rst_n = 0; cfg_wr = 0; cfg_wdata = '0;
      stat_valid = 0; stat_chan = '0; stat_code = '0; sent_valid = 0; sent_chan = '0;
      for (int i = 0; i < 16; i++) budget[i] = 0;
      m_starve = 6; m_hungry = 2;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1");

      // R1/R2/R3: reset limits swept over all channels
      for (int ch = 0; ch < 16; ch++) drain("R2", ch, 2'b00);
      for (int ch = 0; ch < 16; ch++) drain("R3", ch, 2'b01);

      // R11: new limits, junk outside the fields
      write_cfg(32'hFE05_FE01 & 32'hFFFF_FE01 | 32'h0005_0000);
      for (int ch = 0; ch < 16; ch += 3) drain("R2", ch, 2'b00);
      for (int ch = 1; ch < 16; ch += 3) drain("R3", ch, 2'b01);
      write_cfg(32'h0000_0003);
      drain("R2", 4, 2'b00);        // zero starving limit: never allowed
      drain("R3", 5, 2'b01);
      write_cfg({7'h7F, 9'd300, 7'h00, 9'd9});

      // R9: load several channels, touch one, others keep budgets
      for (int ch = 0; ch < 16; ch++) step("R9", 1, ch, (ch % 2 == 0) ? 2'b01 : 2'b00, 0, 0);
      for (int k = 0; k < 9; k++) step("R9", 0, 0, 2'b00, 1, 6);

      // R6: replace, not add
      step("R6", 1, 7, 2'b01, 0, 0);
      for (int k = 0; k < 10; k++) step("R6", 0, 0, 2'b00, 1, 7);

      // R4: satisfied clears a large budget
      step("R4", 1, 3, 2'b10, 0, 0);
      step("R4", 1, 9, 2'b10, 0, 0);

      // R5: code 11 leaves budgets alone (empty and full channels)
      step("R5", 1, 3, 2'b11, 0, 0);
      step("R5", 1, 11, 2'b11, 0, 0);
      step("R5", 1, 6, 2'b11, 0, 0);

      // R10: simultaneous status and sent on same channel
      step("R10", 1, 2, 2'b01, 1, 2);
      for (int k = 0; k < 10; k++) step("R10", 0, 0, 2'b00, 1, 2);
      step("R10", 1, 3, 2'b11, 1, 3);  // no-action status lets sent act
      step("R10", 1, 8, 2'b10, 1, 10); // different channels both act

      // R8: flag timing over a hungry load of 9 on a fresh channel
      step("R8", 1, 12, 2'b10, 0, 0);
      step("R8", 1, 12, 2'b01, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      finished = 1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule